// File: doc/BRIEF.md
# Programmable Static Memory Bus Sequencer

This block turns single requests from an internal port into timed bus cycles for an external static memory. A request carries an address, a direction flag, write data and byte enables. It is taken with a valid/ready handshake. The block then drives the address, the active-low byte selects, the data bus with its drive enable, an active-low chip select and separate active-low read and write strobes. Read data is captured from the bus. It is returned together with a one-clock done pulse.

All timing is counted in clock cycles, and clock 0 is the first clock of an access. Each of four signals has its own setup count (the clock on which it goes low) and its own pulse count (how many clocks it stays low). The four signals are the chip select during reads, the chip select during writes, the read strobe and the write strobe. Reads and writes each have a cycle count that sets the length of the access. Whatever remains after setup and pulse is hold. Two mode bits choose the signal that times the transfer. In read strobe mode, data is captured on the last low clock of the read strobe; otherwise it is captured on the last low clock of the chip select. In write strobe mode, the write strobe times the write; otherwise the chip select does. If the timing signal of a write has zero hold, one extension clock keeps the address, byte selects and data valid after it rises. In write strobe mode the chip select also stays low during that clock.

The sequencer has three states and four transitions:
- ST_IDLE goes to ST_ACCESS when a request is accepted.
- ST_ACCESS goes to ST_IDLE on the last cycle clock when no extension is needed.
- ST_ACCESS goes to ST_EXTEND on the last cycle clock when the write's timing signal has zero hold.
- ST_EXTEND always goes to ST_IDLE.

The programmed values are not checked for legality.

Top module: `stmem_ctrl`

## Requirements
- R1: After reset the block is in ST_IDLE with req_ready high, all strobes and the chip select high, the data bus not driven and done low. The reset timing is setup 1 and pulse 1 for every signal, cycle 3 for both directions, and both mode bits 1.
- R2: During a read, bus_rstb_n is low exactly on clocks S..S+P-1 of the access, using the read strobe fields. During a write, bus_wstb_n is low on the corresponding clocks, using the write strobe fields. The access lasts C clocks, where C is the cycle count for its direction.
- R3: bus_chip_n is low on clocks S..S+P-1, using the chip select fields for the current direction. These fields are independent of the strobe fields.
- R4: With the read mode bit 1, rsp_rdata returns the bus_dq_i value present on the last low clock of bus_rstb_n.
- R5: With the read mode bit 0, rsp_rdata returns the bus_dq_i value present on the last low clock of bus_chip_n.
- R6: During a write, bus_dq_t is high and bus_dq_o carries the write data on every access clock. bus_dq_t is low at all other times, and bus_rstb_n stays high throughout a write.
- R7: A write whose timing signal has zero hold is followed by one extension clock. During that clock the data, address and byte selects stay driven. The timing signal is the write strobe when the write mode bit is 1 and the chip select when it is 0. In the extension clock bus_chip_n is low only when the write mode bit is 1.
- R8: rsp_done is high for exactly one clock, on the clock after the access (including any extension) ends. req_ready is high only in ST_IDLE, so it is low on every access clock and high again together with rsp_done.
- R9: A configuration write takes effect only at the next accepted request, never in the middle of an access.
- R10: bus_addr equals the request address from clock 0 onward and holds until the next access. bus_bsel_n is the inverse of the byte enables on every access clock and all ones in ST_IDLE.
- R11: The register map is as follows. Index 0 holds the setup counts and index 1 the pulse counts, each with byte 0 for the chip select on reads, byte 1 for the read strobe, byte 2 for the chip select on writes and byte 3 for the write strobe. Index 2 holds the cycle counts, with the read cycle in bits 7:0 and the write cycle in bits 23:16. Index 3 holds the mode bits, with the read mode in bit 0 and the write mode in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | Memory address |
| bus_bsel_n | output | DATA_W/8 | Active-low byte selects |
| bus_dq_o | output | DATA_W | Data driven to memory |
| bus_dq_t | output | 1 | Data drive enable |
| bus_dq_i | input | DATA_W | Data from memory |
| bus_chip_n | output | 1 | Active-low chip select |
| bus_rstb_n | output | 1 | Active-low read strobe |
| bus_wstb_n | output | 1 | Active-low write strobe |

## Verification
Accesses are run with the reset timing and with strobe and chip-select windows placed at different offsets and lengths. This separates a chip select that follows its own fields from one that copies the strobe. The memory data changes on every clock, so the captured value shows which clock was sampled; the same read is repeated under each read mode to separate strobe-timed from chip-select-timed capture. Writes are tried with non-zero hold, with zero write-strobe hold under each write mode, and with zero chip-select hold. Together these separate when the extension clock is taken and what the chip select does during it. A configuration write issued mid-access shows whether new values wait for the next request.

// File: rtl/stmem_pkg.sv
package stmem_pkg;

    localparam int FW = 8;
    localparam int SW = FW + 1;

    localparam logic [1:0] REG_SETUP = 2'd0;
    localparam logic [1:0] REG_PULSE = 2'd1;
    localparam logic [1:0] REG_CYCLE = 2'd2;
    localparam logic [1:0] REG_MODE  = 2'd3;

    localparam logic [31:0]   RST_SETUP = {4{8'd1}};
    localparam logic [31:0]   RST_PULSE = {4{8'd1}};
    localparam logic [FW-1:0] RST_CYC   = FW'(3);
    localparam logic [1:0]    RST_MODE  = 2'b11;

    typedef struct packed {
        logic [FW-1:0] s;
        logic [FW-1:0] p;
    } win_t;

    typedef struct packed {
        win_t          chip_rd;
        win_t          rstb;
        win_t          chip_wr;
        win_t          wstb;
        logic [FW-1:0] rcyc;
        logic [FW-1:0] wcyc;
        logic          rd_by_strobe;
        logic          wr_by_strobe;
    } timing_t;

    typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_EXTEND} state_t;

    function automatic timing_t unpack_timing(input logic [31:0] su, input logic [31:0] pu,
                                              input logic [FW-1:0] rc, input logic [FW-1:0] wc,
                                              input logic [1:0] md);
        timing_t t;
        t.chip_rd      = '{s: su[0*FW +: FW], p: pu[0*FW +: FW]};
        t.rstb         = '{s: su[1*FW +: FW], p: pu[1*FW +: FW]};
        t.chip_wr      = '{s: su[2*FW +: FW], p: pu[2*FW +: FW]};
        t.wstb         = '{s: su[3*FW +: FW], p: pu[3*FW +: FW]};
        t.rcyc         = rc;
        t.wcyc         = wc;
        t.rd_by_strobe = md[0];
        t.wr_by_strobe = md[1];
        return t;
    endfunction

endpackage

// File: rtl/stmem_cfg.sv
module stmem_cfg
    import stmem_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic        load,
    output timing_t     active
);

    logic [31:0]   setup_q, pulse_q;
    logic [FW-1:0] rcyc_q, wcyc_q;
    logic [1:0]    mode_q;

    // Programmed values; never visible to a running access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            setup_q <= RST_SETUP;
            pulse_q <= RST_PULSE;
            rcyc_q  <= RST_CYC;
            wcyc_q  <= RST_CYC;
            mode_q  <= RST_MODE;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                REG_SETUP: setup_q <= cfg_wdata;
                REG_PULSE: pulse_q <= cfg_wdata;
                REG_CYCLE: begin
                    rcyc_q <= cfg_wdata[FW-1:0];
                    wcyc_q <= cfg_wdata[16 +: FW];
                end
                REG_MODE:  mode_q <= cfg_wdata[1:0];
                default:   ;
            endcase
        end
    end

    // Snapshot taken when a request is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            active <= unpack_timing(RST_SETUP, RST_PULSE, RST_CYC, RST_CYC, RST_MODE);
        else if (load)
            active <= unpack_timing(setup_q, pulse_q, rcyc_q, wcyc_q, mode_q);
    end

endmodule

// File: rtl/stmem_wave.sv
module stmem_wave
    import stmem_pkg::*;
(
    input  timing_t       t,
    input  logic          is_wr,
    input  logic [FW-1:0] cnt,
    output logic          chip_on,
    output logic          rstb_on,
    output logic          wstb_on,
    output logic          cap_hit,
    output logic          last,
    output logic          ext_need
);

    function automatic logic [SW-1:0] edge_of(input win_t w);
        return {1'b0, w.s} + {1'b0, w.p};
    endfunction

    function automatic logic in_win(input win_t w, input logic [FW-1:0] c);
        return ({1'b0, c} >= {1'b0, w.s}) && ({1'b0, c} < edge_of(w));
    endfunction

    function automatic logic final_clk(input win_t w, input logic [FW-1:0] c);
        return edge_of(w) == ({1'b0, c} + SW'(1));
    endfunction

    win_t          chip_w;
    logic [FW-1:0] cyc;

    always_comb begin
        chip_w   = is_wr ? t.chip_wr : t.chip_rd;
        cyc      = is_wr ? t.wcyc : t.rcyc;
        chip_on  = in_win(chip_w, cnt);
        rstb_on  = !is_wr && in_win(t.rstb, cnt);
        wstb_on  = is_wr && in_win(t.wstb, cnt);
        cap_hit  = !is_wr && (t.rd_by_strobe ? final_clk(t.rstb, cnt)
                                             : final_clk(t.chip_rd, cnt));
        last     = ({1'b0, cnt} + SW'(1)) == {1'b0, cyc};
        ext_need = is_wr && (t.wr_by_strobe ? (edge_of(t.wstb) == {1'b0, t.wcyc})
                                            : (edge_of(t.chip_wr) == {1'b0, t.wcyc}));
    end

endmodule

// File: rtl/stmem_ctrl.sv
module stmem_ctrl
    import stmem_pkg::*;
#(
    parameter  int ADDR_W = 16,
    parameter  int DATA_W = 16,
    localparam int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BE_W-1:0]   bus_bsel_n,
    output logic [DATA_W-1:0] bus_dq_o,
    output logic              bus_dq_t,
    input  logic [DATA_W-1:0] bus_dq_i,
    output logic              bus_chip_n,
    output logic              bus_rstb_n,
    output logic              bus_wstb_n
);

    state_t            state_q, state_d;
    timing_t           active;
    logic              load;
    logic [FW-1:0]     cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic [BE_W-1:0]   be_q;
    logic              wr_q, done_q;
    logic              chip_on, rstb_on, wstb_on, cap_hit, last, ext_need;
    logic              act_wmode;

    stmem_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .load      (load),
        .active    (active)
    );

    stmem_wave u_wave (
        .t        (active),
        .is_wr    (wr_q),
        .cnt      (cnt_q),
        .chip_on  (chip_on),
        .rstb_on  (rstb_on),
        .wstb_on  (wstb_on),
        .cap_hit  (cap_hit),
        .last     (last),
        .ext_need (ext_need)
    );

    assign act_wmode = active.wr_by_strobe;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    load    = 1'b1;
                    state_d = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                if (last) state_d = ext_need ? ST_EXTEND : ST_IDLE;
            end
            ST_EXTEND: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Request latch, cycle counter, capture and done
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            wr_q    <= 1'b0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (state_q == ST_ACCESS && last && !ext_need) || (state_q == ST_EXTEND);
            if (load) begin
                cnt_q   <= '0;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                be_q    <= req_be;
                wr_q    <= req_write;
            end else if (state_q == ST_ACCESS) begin
                cnt_q <= cnt_q + FW'(1);
                if (cap_hit) rdata_q <= bus_dq_i;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        rsp_done   = done_q;
        rsp_rdata  = rdata_q;
        bus_addr   = addr_q;
        bus_dq_o   = wdata_q;
        bus_dq_t   = wr_q && (state_q != ST_IDLE);
        bus_bsel_n = (state_q != ST_IDLE) ? ~be_q : '1;
        bus_chip_n = !((state_q == ST_ACCESS && chip_on) ||
                       (state_q == ST_EXTEND && act_wmode));
        bus_rstb_n = !(state_q == ST_ACCESS && rstb_on);
        bus_wstb_n = !(state_q == ST_ACCESS && wstb_on);
    end

endmodule

// File: rtl/stmem_chk.sv
module stmem_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              bus_chip_n,
    input logic              bus_rstb_n,
    input logic              bus_wstb_n,
    input logic              bus_dq_t,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wmode
);

    a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rstb_n && !bus_wstb_n));

    a_r6_no_read_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dq_t |-> bus_rstb_n);

    a_r7_data_past_wstb: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_wstb_n) && wmode) |-> bus_dq_t);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r8_done_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_rstb_n && bus_wstb_n && !bus_dq_t));

    a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(bus_addr));

endmodule

bind stmem_ctrl stmem_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .bus_chip_n (bus_chip_n),
    .bus_rstb_n (bus_rstb_n),
    .bus_wstb_n (bus_wstb_n),
    .bus_dq_t   (bus_dq_t),
    .bus_addr   (bus_addr),
    .wmode      (act_wmode)
);

// File: tb/stmem_ctrl_test.sv
module stmem_ctrl_test;
    import stmem_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0, bus_dq_i = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_done, bus_dq_t, bus_chip_n, bus_rstb_n, bus_wstb_n;
    logic [15:0] rsp_rdata, bus_addr, bus_dq_o;
    logic [1:0]  bus_bsel_n;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    stmem_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_bsel_n(bus_bsel_n), .bus_dq_o(bus_dq_o), .bus_dq_t(bus_dq_t),
        .bus_dq_i(bus_dq_i), .bus_chip_n(bus_chip_n), .bus_rstb_n(bus_rstb_n), .bus_wstb_n(bus_wstb_n)
    );

    typedef struct packed {
        logic [31:0] su;
        logic [31:0] pu;
        logic [31:0] cy;
        logic [1:0]  md;
        logic        wr;
        logic [15:0] adr;
        logic [15:0] dat;
        logic [1:0]  be;
    } vec_t;

    // setup, pulse, cycle, mode{wr,rd}, write, addr, data, byte enables
    localparam vec_t TABLE [9] = '{
        '{32'h01010101, 32'h01010101, 32'h00030003, 2'b11, 1'b0, 16'h1111, 16'h0000, 2'b11},
        '{32'h01010101, 32'h01010101, 32'h00030003, 2'b11, 1'b1, 16'h2222, 16'hBEEF, 2'b01},
        '{32'h01010201, 32'h01010305, 32'h00030007, 2'b11, 1'b0, 16'h3333, 16'h0000, 2'b10},
        '{32'h01010201, 32'h01010305, 32'h00030007, 2'b10, 1'b0, 16'h4444, 16'h0000, 2'b11},
        '{32'h01000101, 32'h02050101, 32'h00060003, 2'b11, 1'b1, 16'h5555, 16'hC0DE, 2'b11},
        '{32'h02000101, 32'h03050101, 32'h00050003, 2'b11, 1'b1, 16'h6666, 16'h1234, 2'b10},
        '{32'h02000101, 32'h03050101, 32'h00050003, 2'b01, 1'b1, 16'h7777, 16'h5678, 2'b11},
        '{32'h01010101, 32'h04020101, 32'h00050003, 2'b01, 1'b1, 16'h8888, 16'h9ABC, 2'b01},
        '{32'h01010101, 32'h01010202, 32'h00030003, 2'b11, 1'b0, 16'h9999, 16'h0000, 2'b11}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int fld(input logic [31:0] w, input int i);
        return int'(w[i*8 +: 8]);
    endfunction

    function automatic logic [63:0] span(input int s, input int p);
        logic [63:0] m = '0;
        for (int k = 0; k < 64; k++) if (k >= s && k < s + p) m[k] = 1'b1;
        return m;
    endfunction

    task automatic wr_cfg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // v holds the configuration expected to govern this access
    task automatic run_access(input vec_t v, input string grp, input bit mid_we,
                              input logic [1:0] mid_a, input logic [31:0] mid_d);
        int rs = fld(v.su, 1), rp = fld(v.pu, 1);
        int crs = fld(v.su, 0), crp = fld(v.pu, 0);
        int cws = fld(v.su, 2), cwp = fld(v.pu, 2);
        int ws = fld(v.su, 3), wp = fld(v.pu, 3);
        int rc = int'(v.cy[7:0]), wc = int'(v.cy[23:16]);
        int c, ext, n, cap;
        logic [63:0] e_cs, e_rd, e_wr, e_oe, e_dn, e_rdy, o_cs, o_rd, o_wr, o_oe, o_dn, o_rdy;
        bit bus_ok = 1'b1;
        c   = v.wr ? wc : rc;
        ext = (v.wr && (v.md[1] ? (ws + wp == wc) : (cws + cwp == wc))) ? 1 : 0;
        n   = c + ext + 2;
        cap = v.md[0] ? rs + rp - 1 : crs + crp - 1;
        e_cs = v.wr ? span(cws, cwp) : span(crs, crp);
        if (ext == 1 && v.md[1]) e_cs[c] = 1'b1;
        e_rd  = v.wr ? '0 : span(rs, rp);
        e_wr  = v.wr ? span(ws, wp) : '0;
        e_oe  = v.wr ? span(0, c + ext) : '0;
        e_dn  = span(c + ext, 1);
        e_rdy = span(c + ext, 2);
        {o_cs, o_rd, o_wr, o_oe, o_dn, o_rdy} = '0;

        @(negedge clk);
        req_valid = 1'b1; req_write = v.wr; req_addr = v.adr; req_wdata = v.dat; req_be = v.be;
        chk(req_ready == 1'b1, "R8", {grp, " ready before request"}, 64'(req_ready), 64'd1);
        @(posedge clk);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            bus_dq_i  = 16'hA000 + 16'(k);
            if (mid_we) begin
                if (k == 0) begin cfg_we = 1'b1; cfg_addr = mid_a; cfg_wdata = mid_d; end
                else cfg_we = 1'b0;
            end
            o_cs[k]  = !bus_chip_n;
            o_rd[k]  = !bus_rstb_n;
            o_wr[k]  = !bus_wstb_n;
            o_oe[k]  = bus_dq_t;
            o_dn[k]  = rsp_done;
            o_rdy[k] = req_ready;
            if (bus_addr != v.adr) bus_ok = 1'b0;
            if (bus_bsel_n != (k < c + ext ? ~v.be : 2'b11)) bus_ok = 1'b0;
            if (e_oe[k] && bus_dq_o != v.dat) bus_ok = 1'b0;
        end
        chk(o_cs == e_cs, ext ? "R7" : "R3", {grp, " chip select window"}, o_cs, e_cs);
        chk(o_rd == e_rd, "R2", {grp, " read strobe window"}, o_rd, e_rd);
        chk(o_wr == e_wr, "R2", {grp, " write strobe window"}, o_wr, e_wr);
        chk(o_oe == e_oe, ext ? "R7" : "R6", {grp, " data drive window"}, o_oe, e_oe);
        chk(o_dn == e_dn, "R8", {grp, " done pulse"}, o_dn, e_dn);
        chk(o_rdy == e_rdy, "R8", {grp, " ready pattern"}, o_rdy, e_rdy);
        chk(bus_ok, "R10", {grp, " address/byte select/data hold"}, 64'(bus_addr), 64'(v.adr));
        if (!v.wr)
            chk(rsp_rdata == 16'hA000 + 16'(cap), v.md[0] ? "R4" : "R5", {grp, " captured data"},
                64'(rsp_rdata), 64'(16'hA000 + 16'(cap)));
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready && bus_chip_n && bus_rstb_n && bus_wstb_n && !bus_dq_t && !rsp_done
            && bus_bsel_n == 2'b11, "R1", "reset state", 64'({req_ready, bus_chip_n, bus_rstb_n,
            bus_wstb_n, bus_dq_t, rsp_done}), 64'b111100);

        // R1: reset timing with nothing programmed
        run_access(TABLE[0], "R1 default read", 1'b0, 2'd0, 32'd0);
        run_access(TABLE[1], "R1 default write", 1'b0, 2'd0, 32'd0);

        // R11: table walk through the register map
        for (int i = 0; i < 9; i++) begin
            wr_cfg(REG_SETUP, TABLE[i].su);
            wr_cfg(REG_PULSE, TABLE[i].pu);
            wr_cfg(REG_CYCLE, TABLE[i].cy);
            wr_cfg(REG_MODE, {30'd0, TABLE[i].md});
            run_access(TABLE[i], $sformatf("R11 vec%0d", i), 1'b0, 2'd0, 32'd0);
        end

        // R9: a write during an access waits for the next request
        wr_cfg(REG_SETUP, 32'h01010101);
        wr_cfg(REG_PULSE, 32'h01010101);
        wr_cfg(REG_MODE, 32'd3);
        wr_cfg(REG_CYCLE, 32'h00030005);
        v = '{32'h01010101, 32'h01010101, 32'h00030005, 2'b11, 1'b0, 16'hAAAA, 16'h0, 2'b11};
        run_access(v, "R9 old values", 1'b1, REG_PULSE, 32'h01010303);
        v.pu  = 32'h01010303;
        v.adr = 16'hBBBB;
        run_access(v, "R9 new values", 1'b0, 2'd0, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule